// File: doc/BRIEF.md
# Split-Capable Auto-Reload Timer

This block is a 16-bit up-counter timer that can be reconfigured at run time into two separate 8-bit auto-reload timers. Software drives it through a small byte-wide register port: one control register, the two count bytes and the two reload bytes. The counter advances on a single-cycle count tick. That tick is either a divide-by-12 enable or one of two divided-by-8 external enables.

When the counter overflows, it is loaded from its reload value instead of wrapping to zero. Each overflow sets a sticky flag in the control register, and the flags drive a single interrupt request. In capture mode, a selected external tick copies the running count into the reload registers and sets the high-overflow flag. Software can then read back the time stamp.

Top module: `splittmr_top`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Register map at `addr`:
  - 0: control.
  - 1: count low byte.
  - 2: count high byte.
  - 3: reload low byte.
  - 4: reload high byte.
  - Any other address reads 0x00 and ignores writes.
  - A write to a count or reload byte takes priority over a hardware update of that byte in the same cycle.
- R3: Control bit 3 = 0 selects 16-bit mode. With bit 2 (run) = 1, each count tick adds one to the 16-bit count. From 0xFFFF, the count is loaded from the reload pair and control bit 7 (high flag) is set.
- R4: Control bit 6 (low flag) sets on every count tick that advances the low byte from 0xFF, in either mode.
- R5: Hardware never clears bit 7 or bit 6; only a control write does. When a hardware set and a clearing write fall in the same cycle, the flag ends up set.
- R6: Control bit 3 = 1 selects split mode:
  - The low byte advances on every count tick, whatever the run bit. From 0xFF it loads reload low.
  - The high byte advances only while run = 1. From 0xFF it loads reload high and sets bit 7.
- R7: `irq` is high exactly when bit 7 is set, or when bit 6 and bit 5 (low interrupt enable) are both set.
- R8: Count tick selection:
  - Bit 0 = 0: the count tick is `tick_div12`.
  - Bit 0 = 1 and bit 1 = 0: the count tick is `tick_ext_a`.
  - Bit 0 = 1 and bit 1 = 1: the count tick is `tick_ext_b`.
  - The unselected tick inputs have no effect on the count.
- R9: With bit 4 (capture enable) = 1, a capture tick copies the current 16-bit count into the reload pair and sets bit 7 on the next cycle. The capture tick is `tick_ext_b` when bit 1 = 1 and `tick_ext_a` when bit 1 = 0.
- R10: In 16-bit mode with run = 0, the count does not change on any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div12 | input | 1 | One-cycle enable at clock/12 |
| tick_ext_a | input | 1 | First divided-by-8 external tick enable |
| tick_ext_b | input | 1 | Second divided-by-8 external tick enable |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a flag set by hardware in the very cycle that software writes the control register to clear it. The bench first presets the count to 0x00FF. It then drives a count tick and a control write of zero flags on the same clock edge, and expects the low flag to survive. It handles the write-versus-count collision on a count byte in the same way. The split-mode case with the high byte at 0xFF and run set is reached by loading the count bytes directly, so the high reload is exercised within two ticks.

// File: rtl/splittmr_pkg.sv
package splittmr_pkg;
  localparam int CTRL_W = 8;
  // control bit positions, read back by software in this order
  localparam int B_FLAG_HI  = 7;
  localparam int B_FLAG_LO  = 6;
  localparam int B_LO_IEN   = 5;
  localparam int B_CAP_EN   = 4;
  localparam int B_SPLIT    = 3;
  localparam int B_RUN      = 2;
  localparam int B_SRC_SEL  = 1;
  localparam int B_EXT_SEL  = 0;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_CNT_L = 3'd1,
    A_CNT_H = 3'd2,
    A_RLD_L = 3'd3,
    A_RLD_H = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/splittmr_tick_sel.sv
module splittmr_tick_sel (
  input  logic tick_div12,
  input  logic tick_ext_a,
  input  logic tick_ext_b,
  input  logic ext_sel,
  input  logic src_sel,
  input  logic cap_en,
  output logic cnt_tick,
  output logic cap_tick
);
  logic ext_tick;

  always_comb begin
    ext_tick = src_sel ? tick_ext_b : tick_ext_a;
    cnt_tick = ext_sel ? ext_tick : tick_div12;
    cap_tick = cap_en & ext_tick;
  end
endmodule

// File: rtl/splittmr_byte.sv
module splittmr_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] rld,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = wr | load | inc;
    if (wr)        cnt_d = wr_val;
    else if (load) cnt_d = rld;
    else           cnt_d = cnt + W'(1);
    at_max = (cnt == {W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/splittmr_top.sv
module splittmr_top
  import splittmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_div12,
  input  logic              tick_ext_a,
  input  logic              tick_ext_b,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int N_BYTE = 2;

  logic [1:0]          rst_sync;
  logic                rst_int_n;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic [CNT_W-1:0]    count_q, reload_q, reload_d;
  logic                cnt_tick, cap_tick;
  logic                split, run;
  logic [N_BYTE-1:0]   b_inc, b_load, b_max, b_wr;
  logic [BYTE_W-1:0]   b_cnt [N_BYTE];
  logic [BYTE_W-1:0]   b_rld [N_BYTE];
  logic                lo_roll, hi_roll;
  logic                wr_ctrl, wr_rld_l, wr_rld_h;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign split = ctrl_q[B_SPLIT];
  assign run   = ctrl_q[B_RUN];

  splittmr_tick_sel u_tick (
    .tick_div12 (tick_div12),
    .tick_ext_a (tick_ext_a),
    .tick_ext_b (tick_ext_b),
    .ext_sel    (ctrl_q[B_EXT_SEL]),
    .src_sel    (ctrl_q[B_SRC_SEL]),
    .cap_en     (ctrl_q[B_CAP_EN]),
    .cnt_tick   (cnt_tick),
    .cap_tick   (cap_tick)
  );

  // byte advance and reload decisions
  always_comb begin
    b_wr[0]   = wr_en && (addr == ADDR_W'(A_CNT_L));
    b_wr[1]   = wr_en && (addr == ADDR_W'(A_CNT_H));
    b_inc[0]  = cnt_tick & (split | run);
    b_inc[1]  = split ? (cnt_tick & run) : (b_inc[0] & b_max[0]);
    b_load[0] = b_inc[0] & b_max[0] & (split | b_max[1]);
    b_load[1] = b_inc[1] & b_max[1];
    lo_roll   = b_inc[0] & b_max[0];
    hi_roll   = b_inc[1] & b_max[1];
  end

  for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
    assign b_rld[i] = reload_q[i*BYTE_W +: BYTE_W];
    splittmr_byte #(.W(BYTE_W)) u_byte (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr     (b_wr[i]),
      .wr_val (wr_data),
      .inc    (b_inc[i]),
      .load   (b_load[i]),
      .rld    (b_rld[i]),
      .cnt    (b_cnt[i]),
      .at_max (b_max[i])
    );
  end

  assign count_q = {b_cnt[1], b_cnt[0]};

  // control and reload next state
  always_comb begin
    wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
    wr_rld_l = wr_en && (addr == ADDR_W'(A_RLD_L));
    wr_rld_h = wr_en && (addr == ADDR_W'(A_RLD_H));

    ctrl_d = wr_ctrl ? wr_data : ctrl_q;
    ctrl_d[B_FLAG_HI] = ctrl_d[B_FLAG_HI] | hi_roll | cap_tick;
    ctrl_d[B_FLAG_LO] = ctrl_d[B_FLAG_LO] | lo_roll;

    reload_d = cap_tick ? count_q : reload_q;
    if (wr_rld_l) reload_d[BYTE_W-1:0]     = wr_data;
    if (wr_rld_h) reload_d[CNT_W-1:BYTE_W] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    irq = ctrl_q[B_FLAG_HI] | (ctrl_q[B_FLAG_LO] & ctrl_q[B_LO_IEN]);
    case (addr)
      ADDR_W'(A_CTRL):  rd_data = ctrl_q;
      ADDR_W'(A_CNT_L): rd_data = b_cnt[0];
      ADDR_W'(A_CNT_H): rd_data = b_cnt[1];
      ADDR_W'(A_RLD_L): rd_data = reload_q[BYTE_W-1:0];
      ADDR_W'(A_RLD_H): rd_data = reload_q[CNT_W-1:BYTE_W];
      default:          rd_data = '0;
    endcase
  end
endmodule

// File: rtl/splittmr_chk.sv
module splittmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             tick_div12,
  input logic             tick_ext_a,
  input logic             tick_ext_b,
  input logic [7:0]       ctrl_q,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             irq
);
  localparam int HB = CNT_W / 2;

  a_r5_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] && !wr_en |=> ctrl_q[7]);

  a_r5_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6] && !wr_en |=> ctrl_q[6]);

  a_r6_hi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[3] && !ctrl_q[2] && !wr_en |=> count_q[CNT_W-1:HB] == $past(count_q[CNT_W-1:HB]));

  a_r7_irq_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |-> irq);

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[7] && !ctrl_q[5] |-> !irq);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_div12 && !tick_ext_a && !tick_ext_b && !wr_en |=> $stable(count_q));

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] && (ctrl_q[1] ? tick_ext_b : tick_ext_a) && !wr_en
    |=> (reload_q == $past(count_q)) && ctrl_q[7]);

  a_r10_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[3] && !ctrl_q[2] && !wr_en |=> $stable(count_q));
endmodule

bind splittmr_top splittmr_chk #(.CNT_W(2*BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .wr_en      (wr_en),
  .tick_div12 (tick_div12),
  .tick_ext_a (tick_ext_a),
  .tick_ext_b (tick_ext_b),
  .ctrl_q     (ctrl_q),
  .count_q    (count_q),
  .reload_q   (reload_q),
  .irq        (irq)
);

// File: tb/splittmr_top_test.sv
`timescale 1ns/1ps
module splittmr_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       t_div12 = 1'b0, t_a = 1'b0, t_b = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;
  int         checks = 0;
  int         failures = 0;
  logic [7:0] v_lo, v_hi;

  always #4 clk = ~clk;

  splittmr_top uut (
    .clk(clk), .rst_n(rst_n), .tick_div12(t_div12), .tick_ext_a(t_a),
    .tick_ext_b(t_b), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] rld;
    logic [15:0] start;
    logic [3:0]  n;
    logic [1:0]  src;      // 0 div12, 1 ext_a, 2 ext_b
    logic [15:0] exp_cnt;
    logic [7:0]  exp_ctrl;
    logic [23:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h04, 16'h1234, 16'h00FE, 4'd3, 2'd0, 16'h0101, 8'h44, "R4 "},
    '{8'h04, 16'h1234, 16'hFFFE, 4'd3, 2'd0, 16'h1235, 8'hC4, "R3 "},
    '{8'h00, 16'h1234, 16'h5000, 4'd5, 2'd0, 16'h5000, 8'h00, "R10"},
    '{8'h08, 16'h2080, 16'h10FE, 4'd3, 2'd0, 16'h1081, 8'h48, "R6 "},
    '{8'h0C, 16'h2000, 16'hFF10, 4'd2, 2'd0, 16'h2112, 8'h8C, "R6 "},
    '{8'h05, 16'h0000, 16'h0010, 4'd4, 2'd1, 16'h0014, 8'h05, "R8 "},
    '{8'h07, 16'h0000, 16'h0010, 4'd4, 2'd1, 16'h0010, 8'h07, "R8 "},
    '{8'h07, 16'h0000, 16'h00FF, 4'd2, 2'd2, 16'h0101, 8'h47, "R8 "},
    '{8'h04, 16'h0000, 16'h0200, 4'd3, 2'd1, 16'h0200, 8'h04, "R8 "}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (src)
        0: t_div12 = 1'b1;
        1: t_a = 1'b1;
        default: t_b = 1'b1;
      endcase
      @(negedge clk);
      t_div12 = 1'b0; t_a = 1'b0; t_b = 1'b0;
    end
  endtask

  task automatic load(input logic [15:0] cnt, input logic [15:0] rl);
    wr(3'd0, 8'h00);
    wr(3'd1, cnt[7:0]); wr(3'd2, cnt[15:8]);
    wr(3'd3, rl[7:0]);  wr(3'd4, rl[15:8]);
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    rd(3'd1, v_lo); rd(3'd2, v_hi);
    c = {v_hi, v_lo};
  endtask

  initial begin : watchdog
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] c;
    logic [7:0]  r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      check("R1", "reset reg", {8'h0, r}, 16'h0000);
    end
    check("R1", "reset irq", {15'h0, irq}, 16'h0000);

    // R2 unmapped address
    wr(3'd7, 8'hAA);
    rd(3'd7, r);
    check("R2", "unmapped read", {8'h0, r}, 16'h0000);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      check("R2", "unmapped write side effect", {8'h0, r}, 16'h0000);
    end

    // vector table
    for (int i = 0; i < NV; i++) begin
      load(VEC[i].start, VEC[i].rld);
      wr(3'd0, VEC[i].ctrl);
      pulse(int'(VEC[i].src), int'(VEC[i].n));
      rd_cnt(c);
      check(string'(VEC[i].req), $sformatf("vector %0d count", i), c, VEC[i].exp_cnt);
      rd(3'd0, r);
      check(string'(VEC[i].req), $sformatf("vector %0d ctrl", i), {8'h0, r}, {8'h0, VEC[i].exp_ctrl});
    end

    // R5 set wins over clearing write
    load(16'h00FF, 16'h0000);
    wr(3'd0, 8'h44);
    @(negedge clk);
    addr = 3'd0; wr_data = 8'h04; wr_en = 1'b1; t_div12 = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; t_div12 = 1'b0;
    rd(3'd0, r);
    check("R5", "set beats clear", {8'h0, r}, 16'h0044);
    // R5 sticky across non-rolling ticks
    pulse(0, 3);
    rd(3'd0, r);
    check("R5", "flag sticky", {8'h0, r}, 16'h0044);
    wr(3'd0, 8'h04);
    rd(3'd0, r);
    check("R5", "write clears", {8'h0, r}, 16'h0004);

    // R2 write wins over count
    load(16'h0010, 16'h0000);
    wr(3'd0, 8'h04);
    @(negedge clk);
    addr = 3'd1; wr_data = 8'h55; wr_en = 1'b1; t_div12 = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; t_div12 = 1'b0;
    rd_cnt(c);
    check("R2", "write beats count", c, 16'h0055);

    // R7 interrupt request
    wr(3'd0, 8'h40);
    check("R7", "lo flag masked", {15'h0, irq}, 16'h0000);
    wr(3'd0, 8'h60);
    check("R7", "lo flag enabled", {15'h0, irq}, 16'h0001);
    wr(3'd0, 8'h20);
    check("R7", "enable without flag", {15'h0, irq}, 16'h0000);
    wr(3'd0, 8'h80);
    check("R7", "hi flag", {15'h0, irq}, 16'h0001);

    // R9 capture on ext_a while counting div12
    load(16'h0300, 16'h1111);
    wr(3'd0, 8'h14);
    pulse(0, 2);
    pulse(2, 1);
    rd(3'd3, v_lo); rd(3'd4, v_hi);
    check("R9", "no capture on unselected tick", {v_hi, v_lo}, 16'h1111);
    pulse(1, 1);
    rd(3'd3, v_lo); rd(3'd4, v_hi);
    check("R9", "captured value", {v_hi, v_lo}, 16'h0302);
    rd(3'd0, r);
    check("R9", "capture sets hi flag", {8'h0, r}, 16'h0094);
    check("R9", "capture irq", {15'h0, irq}, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule